// File: doc/BRIEF.md
# Programmable Half-Duty Clock Divider With Odd Ratios

This block takes a fast input clock and produces a divided clock whose ratio is chosen by a two-bit code. The four ratios run from three to six. The output spends exactly half of every output period high, including at the odd ratios. For those ratios the extra half input period is produced by a phase register clocked on the falling edge of the input clock.

The divided clock drives two output pins. Each pin has its own enable, and a pin whose enable is low floats at high impedance. A high master reset clears the divider and forces both pins low, whatever their enables are.

A new ratio code is taken only when the divider starts a fresh output period. As a result, the last period at the old ratio always completes at its full length, and no shortened pulse can appear. The code may change at any time. A value that is gone again before the next period boundary has no effect.

Top module: `odd_even_clkdiv`

## Requirements
- R1: The output period is 3, 4, 5 or 6 input clock periods for ratio codes 0, 1, 2 and 3 respectively (ratio = 3 + code).
- R2: For every ratio N, the output is high for exactly N/2 input periods and low for exactly N/2 input periods. For odd N, the falling edge of the output lands on a falling edge of the input clock.
- R3: While `rst` is high, both `q0` and `q1` are driven to 0, regardless of `oe0` and `oe1`.
- R4: After `rst` falls, the output stays low until the first rising input edge and goes high at that edge, which begins the first output period.
- R5: A pin whose enable is 0 is at high impedance and a pin whose enable is 1 is driven. The enables act independently, so {oe0,oe1} = 00, 01, 10 and 11 float both pins, drive only `q1`, drive only `q0`, and drive both pins.
- R6: When both pins are enabled they carry the same waveform, with aligned edges.
- R7: A code change made partway through an output period does not alter that period. The new ratio applies from the next rising output edge.
- R8: A code value that is applied and then withdrawn within a single output period has no effect on any output period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Master reset, active high, asynchronous |
| ratio_code | input | 2 | Ratio select; ratio = 3 + code |
| oe0 | input | 1 | Enable for `q0`; 0 floats the pin |
| oe1 | input | 1 | Enable for `q1`; 0 floats the pin |
| q0 | output | 1 | First divided clock pin (tri-state) |
| q1 | output | 1 | Second divided clock pin (tri-state) |

## Verification
The outputs follow the pin enables and the reset without any register in between, so the bench checks those pins 1 ns after it changes the control. Divider results are timed from rising input edges. A rising output edge appears at the same input edge where the counter wraps. The falling edge follows N/2 input periods later, which for odd N is on a falling input edge. The bench therefore measures edge times with timestamps and compares them with widths of exactly 2·N ns at the 4 ns input period.

For a code change, the expected waveform is worked out from the input edge where the change is made. The period already running keeps its old length, and the following one uses the new length. Pin equality is sampled 1 ns after each input edge, away from the moments when the outputs switch.

// File: rtl/oeclk_pkg.sv
`timescale 1ns/1ps
package oeclk_pkg;
  localparam int CODE_W     = 2;
  localparam int BASE_RATIO = 3;
  localparam int MAX_RATIO  = BASE_RATIO + (1 << CODE_W) - 1;
  localparam int CNT_W      = $clog2(MAX_RATIO + 1);

  // ratio = BASE_RATIO + code
  function automatic logic [CNT_W-1:0] ratio_of(input logic [CODE_W-1:0] code);
    return CNT_W'(BASE_RATIO) + CNT_W'(code);
  endfunction

  // number of whole input periods the rising-edge phase stays high
  function automatic logic [CNT_W-1:0] high_cycles(input logic [CNT_W-1:0] ratio);
    return ratio >> 1;
  endfunction

  function automatic logic is_odd(input logic [CNT_W-1:0] ratio);
    return ratio[0];
  endfunction
endpackage

// File: rtl/oeclk_counter.sv
`timescale 1ns/1ps
module oeclk_counter
  import oeclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  ratio_q,
  output logic [CNT_W-1:0]  cnt_nx,
  output logic [CNT_W-1:0]  ratio_nx,
  output logic              wrap
);
  logic armed_q;

  // the first edge after reset release always starts a period
  assign wrap     = !armed_q || (cnt_q == ratio_q - CNT_W'(1));
  assign cnt_nx   = wrap ? '0 : cnt_q + CNT_W'(1);
  assign ratio_nx = wrap ? ratio_of(code) : ratio_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      ratio_q <= CNT_W'(BASE_RATIO);
    end else begin
      armed_q <= 1'b1;
      cnt_q   <= cnt_nx;
      ratio_q <= ratio_nx;
    end
  end

  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (cnt_q < ratio_q));

  assert_ratio_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(ratio_q) |-> (cnt_q == '0));

  assert_ratio_legal_R1: assert property (@(posedge clk) disable iff (rst)
    (ratio_q >= CNT_W'(BASE_RATIO)) && (ratio_q <= CNT_W'(MAX_RATIO)));
endmodule

// File: rtl/oeclk_shaper.sv
`timescale 1ns/1ps
module oeclk_shaper
  import oeclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_nx,
  input  logic [CNT_W-1:0] ratio_nx,
  input  logic [CNT_W-1:0] ratio_q,
  input  logic             wrap,
  output logic             div_clk
);
  logic ph_rise_q;  // rising-edge phase: high for floor(N/2) periods
  logic ph_fall_q;  // same phase delayed by half an input period

  always_ff @(posedge clk or posedge rst) begin
    if (rst) ph_rise_q <= 1'b0;
    else     ph_rise_q <= (cnt_nx < high_cycles(ratio_nx));
  end

  always_ff @(negedge clk or posedge rst) begin
    if (rst) ph_fall_q <= 1'b0;
    else     ph_fall_q <= ph_rise_q;
  end

  // odd ratios stretch the high phase by the half-period lag
  assign div_clk = is_odd(ratio_q) ? (ph_rise_q | ph_fall_q) : ph_rise_q;

  assert_rise_on_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ph_rise_q);

  assert_half_lag_R2: assert property (@(posedge clk) disable iff (rst)
    ph_fall_q == ph_rise_q);

  assert_low_before_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    wrap |-> !ph_fall_q);
endmodule

// File: rtl/oeclk_pads.sv
`timescale 1ns/1ps
module oeclk_pads #(
  parameter int NUM_PORTS = 2
) (
  input  logic                 rst,
  input  logic                 div_clk,
  input  logic [NUM_PORTS-1:0] oe,
  output logic [NUM_PORTS-1:0] drv_en,
  output logic [NUM_PORTS-1:0] drv_val
);
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_pad
    assign drv_en[i]  = rst | oe[i];
    assign drv_val[i] = !rst & div_clk;
  end
endmodule

// File: rtl/odd_even_clkdiv.sv
`timescale 1ns/1ps
module odd_even_clkdiv
  import oeclk_pkg::*;
(
  input  logic              clk_in,
  input  logic              rst,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic              oe0,
  input  logic              oe1,
  output wire               q0,
  output wire               q1
);
  localparam int NUM_PORTS = 2;

  logic [CNT_W-1:0]     cnt_q, ratio_q, cnt_nx, ratio_nx;
  logic                 wrap;
  logic                 div_clk;
  logic [NUM_PORTS-1:0] drv_en, drv_val;

  oeclk_counter u_cnt (
    .clk(clk_in), .rst(rst), .code(ratio_code),
    .cnt_q(cnt_q), .ratio_q(ratio_q), .cnt_nx(cnt_nx),
    .ratio_nx(ratio_nx), .wrap(wrap)
  );

  oeclk_shaper u_shape (
    .clk(clk_in), .rst(rst), .cnt_nx(cnt_nx), .ratio_nx(ratio_nx),
    .ratio_q(ratio_q), .wrap(wrap), .div_clk(div_clk)
  );

  oeclk_pads #(.NUM_PORTS(NUM_PORTS)) u_pads (
    .rst(rst), .div_clk(div_clk), .oe({oe1, oe0}),
    .drv_en(drv_en), .drv_val(drv_val)
  );

  assign q0 = drv_en[0] ? drv_val[0] : 1'bz;
  assign q1 = drv_en[1] ? drv_val[1] : 1'bz;

  assert_reset_low_R3: assert property (@(posedge clk_in)
    rst |-> (drv_en == '1) && (drv_val == '0));

  assert_pins_aligned_R6: assert property (@(posedge clk_in) disable iff (rst)
    (oe0 && oe1) |-> (drv_val[0] == drv_val[1]));

  assert_enable_follows_R5: assert property (@(posedge clk_in) disable iff (rst)
    drv_en == {oe1, oe0});
endmodule

// File: tb/tb_odd_even_clkdiv.sv
`timescale 1ns/1ps
module tb_odd_even_clkdiv;
  localparam real PER = 4.0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] code = 2'd0;
  logic       oe0 = 1'b1;
  logic       oe1 = 1'b1;
  wire        q0, q1;
  int         total = 0;
  int         bad = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  odd_even_clkdiv dut (
    .clk_in(clk), .rst(rst), .ratio_code(code),
    .oe0(oe0), .oe1(oe1), .q0(q0), .q1(q1)
  );

  function automatic real lv(input logic v);
    case (v)
      1'b0:    return 0.0;
      1'b1:    return 1.0;
      1'bz:    return 2.0;
      default: return 3.0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0.2f expected=%0.2f", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic measure(output real hi, output real lo);
    realtime t1, t2, t3;
    @(posedge q0); t1 = $realtime;
    @(negedge q0); t2 = $realtime;
    @(posedge q0); t3 = $realtime;
    hi = t2 - t1;
    lo = t3 - t2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_up();
  end

  initial begin
    real     hi, lo;
    realtime t0, tf, tr, tf2, tr3;
    int      mism;

    // R3: outputs low while reset is held, even if a pin is disabled
    repeat (3) @(negedge clk); #1;
    check(q0 === 1'b0, "R3", "q0 in reset", lv(q0), 0.0);
    check(q1 === 1'b0, "R3", "q1 in reset", lv(q1), 0.0);
    oe0 = 1'b0; #1;
    check(q0 === 1'b0, "R3", "q0 in reset with oe0=0", lv(q0), 0.0);
    oe0 = 1'b1;

    // R4: first rising output edge at first rising input edge after release
    code = 2'd0;
    @(negedge clk); #1 rst = 1'b0;
    #0.5;
    check(q0 === 1'b0, "R4", "q0 before first edge", lv(q0), 0.0);
    @(posedge clk); #1;
    check(q0 === 1'b1, "R4", "q0 after first edge", lv(q0), 1.0);

    // R1, R2, R6: sweep every ratio code
    for (int c = 0; c < 4; c++) begin
      int n;
      n = 3 + c;
      code = 2'(c);
      repeat (3) measure(hi, lo);
      measure(hi, lo);
      check(hi == n * PER / 2.0, "R2", "high width ns", hi, n * PER / 2.0);
      check(lo == n * PER / 2.0, "R2", "low width ns", lo, n * PER / 2.0);
      check(hi + lo == n * PER, "R1", "period ns", hi + lo, n * PER);
      mism = 0;
      repeat (4 * n) begin
        @(posedge clk); #1;
        if (q0 !== q1) mism++;
        @(negedge clk); #1;
        if (q0 !== q1) mism++;
      end
      check(mism == 0, "R6", "pin mismatches", mism, 0.0);
    end

    // R5: every enable combination, {oe0,oe1}
    for (int e = 0; e < 4; e++) begin
      {oe0, oe1} = 2'(e);
      repeat (2) @(negedge clk); #1;
      check((q0 === 1'bz) == (e[1] == 1'b0), "R5", "q0 float state", lv(q0), e[1] ? 0.0 : 2.0);
      check((q1 === 1'bz) == (e[0] == 1'b0), "R5", "q1 float state", lv(q1), e[0] ? 0.0 : 2.0);
    end
    oe0 = 1'b1; oe1 = 1'b1;

    // R7: switch ratio 4 -> 6 in the second input period of an output period
    rst = 1'b1; code = 2'd1;
    repeat (2) @(negedge clk); #1 rst = 1'b0;
    @(posedge clk); t0 = $realtime;
    @(negedge clk); @(posedge clk); @(negedge clk);
    code = 2'd3;
    @(negedge q0); tf  = $realtime;
    @(posedge q0); tr  = $realtime;
    @(negedge q0); tf2 = $realtime;
    @(posedge q0); tr3 = $realtime;
    check(tf - t0 == 8.0,  "R7", "old high width ns", tf - t0, 8.0);
    check(tr - t0 == 16.0, "R7", "old period ns", tr - t0, 16.0);
    check(tf2 - tr == 12.0, "R7", "new high width ns", tf2 - tr, 12.0);
    check(tr3 - tf2 == 12.0, "R7", "new low width ns", tr3 - tf2, 12.0);

    // R8: code 0 shown briefly inside a ratio-5 period, then withdrawn
    code = 2'd2;
    repeat (3) measure(hi, lo);
    @(posedge q0); tr = $realtime;
    @(negedge clk); code = 2'd0;
    @(negedge clk); code = 2'd2;
    @(negedge q0); tf  = $realtime;
    @(posedge q0); tr3 = $realtime;
    check(tf - tr == 10.0,  "R8", "high width ns", tf - tr, 10.0);
    check(tr3 - tr == 20.0, "R8", "period ns", tr3 - tr, 20.0);
    measure(hi, lo);
    check(hi + lo == 20.0, "R8", "following period ns", hi + lo, 20.0);

    finish_up();
  end
endmodule